// File: doc/BRIEF.md
# Coincidence Sync Generator

This block derives two divided clocks, bank A and bank C, from one master clock and drives an active-low warning flag ahead of every rising edge the two share. Each divided clock comes from its own phase counter. Both counters leave reset at phase zero, so the clocks rise together once every LCM(ratio A, ratio C) master cycles. The flag drops exactly one period of the faster bank clock (min(ratio A, ratio C) master cycles) before such a shared edge and comes back high on the shared edge itself. Logic clocked by the slower bank can therefore prepare a transfer that lines up with the other bank, including when the ratio between the banks is not an integer, such as 3:2.

Both ratios are sampled while reset is held and again at each shared edge. A new ratio only takes effect at the start of a new coincidence period. The banks keep a common phase reference, and each warning window is computed from the ratios in force during the period it belongs to. All outputs are registered on the master clock and follow the phase counters by one cycle.

Top module: `coin_sync_gen`

## Requirements
- R1: While `rst` is high, `sync_n` is 1 and both bank clocks are 0. Both ratios are captured during reset.
- R2: Counting post-reset master cycles from k = 0, the outputs after cycle k show bank X clock = 1 exactly when (k mod ratio X) < floor(ratio X / 2). Each bank clock rises at phase 0, and both banks start at phase 0.
- R3: A ratio input below 2 (0 or 1) is treated as a ratio of 2.
- R4: With F = min(ratio A, ratio C) and L = LCM(ratio A, ratio C), `sync_n` is 0 exactly when (k mod L) >= L - F. Every coincidence period therefore holds exactly F low cycles, and they end just before the shared edge.
- R5: `sync_n` returns to 1 in the cycle in which both bank clocks rise together. It is 1 in every cycle outside the windows.
- R6: Non-integer ratios work. For ratios 3 and 2, the window covers phases 4 and 5 of every 6-cycle period.
- R7: When the two ratios are equal, every edge is shared. Each window then spans a whole period, so `sync_n` stays 0 from the first cycle after reset.
- R8: A ratio change is applied only at the next shared edge. Both counters restart at phase 0 with the new ratios, and the window width is recomputed there.
- R9: `sync_n` falls in the same cycle as a rising edge of the faster bank clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_a | input | DIV_W | Divide ratio of bank A |
| ratio_c | input | DIV_W | Divide ratio of bank C |
| bank_a_clk | output | 1 | Divided clock of bank A |
| bank_c_clk | output | 1 | Divided clock of bank C |
| sync_n | output | 1 | Active-low warning of the next shared rising edge |

## Verification
The bench builds the block with the default 5-bit ratio width. This width covers every ratio in the sweep {2,4,6,8} x {4,6,8,12}, as well as the clamped values 0 and 1 and the odd ratio 3. Within this range the bench reaches:
- coincidence periods as long as 24 master cycles;
- the equal-ratio case, where the windows touch end to end;
- a ratio change in the middle of a period, which shows the new width is deferred to the next shared edge.

For each pair, the bank clocks and the flag are compared cycle by cycle over two full coincidence periods.

// File: rtl/coin_sync_pkg.sv
package coin_sync_pkg;

  // Which bank runs the faster (shorter) divided clock.
  typedef enum logic {
    FAST_A = 1'b0,
    FAST_C = 1'b1
  } fast_sel_e;

  localparam int unsigned CS_DIV_W   = 5;
  localparam int unsigned CS_MIN_DIV = 2;
  localparam int unsigned CS_BANKS   = 2;

endpackage

// File: rtl/cs_ratio_latch.sv
module cs_ratio_latch
  import coin_sync_pkg::*;
#(
  parameter int unsigned DIV_W = CS_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_a_in,
  input  logic [DIV_W-1:0] div_c_in,
  input  logic             load,
  output logic [DIV_W-1:0] div_a_q,
  output logic [DIV_W-1:0] div_c_q,
  output logic [DIV_W-1:0] fast_q,
  output logic [DIV_W-1:0] slow_off_q,
  output fast_sel_e        fast_sel_q
);

  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(CS_MIN_DIV);

  logic [DIV_W-1:0] a_cl;
  logic [DIV_W-1:0] c_cl;

  // Ratios below the minimum are raised to it.
  always_comb begin
    a_cl = (div_a_in < MIN_DIV) ? MIN_DIV : div_a_in;
    c_cl = (div_c_in < MIN_DIV) ? MIN_DIV : div_c_in;
  end

  // Capture during reset and on each shared edge. The fast ratio and the
  // slow counter's start offset are precomputed here so that the window
  // detector only needs two equality compares.
  always_ff @(posedge clk) begin
    if (rst || load) begin
      div_a_q <= a_cl;
      div_c_q <= c_cl;
      if (a_cl <= c_cl) begin
        fast_q     <= a_cl;
        slow_off_q <= c_cl - a_cl;
        fast_sel_q <= FAST_A;
      end else begin
        fast_q     <= c_cl;
        slow_off_q <= a_cl - c_cl;
        fast_sel_q <= FAST_C;
      end
    end
  end

  AST_CFG_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (div_a_q >= MIN_DIV) && (div_c_q >= MIN_DIV)); // R3

endmodule

// File: rtl/cs_divider.sv
module cs_divider
  import coin_sync_pkg::*;
#(
  parameter int unsigned DIV_W = CS_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic [DIV_W-1:0] cnt_q,
  output logic             wrap,
  output logic             bank_clk_q
);

  logic [DIV_W-1:0] half;

  always_comb begin
    half = div >> 1;
    wrap = (cnt_q == (div - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      bank_clk_q <= 1'b0;
    end else begin
      bank_clk_q <= (cnt_q < half);
      cnt_q      <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q < div); // R2

endmodule

// File: rtl/cs_window.sv
module cs_window
  import coin_sync_pkg::*;
#(
  parameter int unsigned DIV_W = CS_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cnt_a,
  input  logic [DIV_W-1:0] cnt_c,
  input  logic [DIV_W-1:0] fast,
  input  logic [DIV_W-1:0] slow_off,
  input  fast_sel_e        fast_sel,
  output logic             sync_n_q
);

  logic [DIV_W-1:0] rem_q;
  logic             start;
  logic             low_now;

  // A shared edge lies exactly 'fast' cycles ahead when the fast counter
  // sits at phase 0 and the slow counter sits at (slow - fast).
  always_comb begin
    if (fast_sel == FAST_A) begin
      start = (cnt_a == '0) && (cnt_c == slow_off);
    end else begin
      start = (cnt_c == '0) && (cnt_a == slow_off);
    end
    low_now = start || (rem_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q    <= '0;
      sync_n_q <= 1'b1;
    end else begin
      if (start) begin
        rem_q <= fast - 1'b1;
      end else if (rem_q != '0) begin
        rem_q <= rem_q - 1'b1;
      end
      sync_n_q <= !low_now;
    end
  end

  AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    rem_q < fast); // R4

endmodule

// File: rtl/coin_sync_gen.sv
module coin_sync_gen
  import coin_sync_pkg::*;
#(
  parameter int unsigned DIV_W = CS_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] ratio_a,
  input  logic [DIV_W-1:0] ratio_c,
  output logic             bank_a_clk,
  output logic             bank_c_clk,
  output logic             sync_n
);

  localparam int unsigned NB = CS_BANKS;

  logic [DIV_W-1:0] div_a_q;
  logic [DIV_W-1:0] div_c_q;
  logic [DIV_W-1:0] fast_q;
  logic [DIV_W-1:0] slow_off_q;
  fast_sel_e        fast_sel_q;

  logic [DIV_W-1:0] div_arr [NB];
  logic [DIV_W-1:0] cnt_arr [NB];
  logic             wrap_arr[NB];
  logic             clk_arr [NB];
  logic             coin_wrap;

  assign div_arr[0] = div_a_q;
  assign div_arr[1] = div_c_q;
  assign coin_wrap  = wrap_arr[0] && wrap_arr[1];

  cs_ratio_latch #(.DIV_W(DIV_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .div_a_in   (ratio_a),
    .div_c_in   (ratio_c),
    .load       (coin_wrap),
    .div_a_q    (div_a_q),
    .div_c_q    (div_c_q),
    .fast_q     (fast_q),
    .slow_off_q (slow_off_q),
    .fast_sel_q (fast_sel_q)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    cs_divider #(.DIV_W(DIV_W)) u_div (
      .clk        (clk),
      .rst        (rst),
      .div        (div_arr[b]),
      .cnt_q      (cnt_arr[b]),
      .wrap       (wrap_arr[b]),
      .bank_clk_q (clk_arr[b])
    );
  end

  cs_window #(.DIV_W(DIV_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .cnt_a    (cnt_arr[0]),
    .cnt_c    (cnt_arr[1]),
    .fast     (fast_q),
    .slow_off (slow_off_q),
    .fast_sel (fast_sel_q),
    .sync_n_q (sync_n)
  );

  assign bank_a_clk = clk_arr[0];
  assign bank_c_clk = clk_arr[1];

  AST_RISE_AT_COIN: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> ($rose(bank_a_clk) && $rose(bank_c_clk))); // R5

  AST_FALL_ON_FAST: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_n) |-> ($rose(bank_a_clk) || $rose(bank_c_clk))); // R9

  AST_COIN_RELOAD: assert property (@(posedge clk) disable iff (rst)
    coin_wrap |=> ((cnt_arr[0] == '0) && (cnt_arr[1] == '0))); // R8

endmodule

// File: tb/tb_coin_sync_gen.sv
module tb_coin_sync_gen;

  localparam int unsigned DIV_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] ratio_a = DIV_W'(4);
  logic [DIV_W-1:0] ratio_c = DIV_W'(6);
  logic             bank_a_clk;
  logic             bank_c_clk;
  logic             sync_n;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  coin_sync_gen #(.DIV_W(DIV_W)) dut (
    .clk        (clk),
    .rst        (rst),
    .ratio_a    (ratio_a),
    .ratio_c    (ratio_c),
    .bank_a_clk (bank_a_clk),
    .bank_c_clk (bank_c_clk),
    .sync_n     (sync_n)
  );

  function automatic int gcd(int x, int y);
    int a = x;
    int b = y;
    while (b != 0) begin
      int t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  function automatic int eff(int r);
    return (r < 2) ? 2 : r;
  endfunction

  function automatic logic exp_clk(int k, int d);
    return ((k % d) < (d / 2)) ? 1'b1 : 1'b0;
  endfunction

  function automatic logic exp_sync(int k, int a, int c);
    int l = a * c / gcd(a, c);
    int f = (a < c) ? a : c;
    return ((k % l) >= (l - f)) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(string tag, logic act, logic exp, int k);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s k=%0d actual=%b expected=%b", tag, k, act, exp);
    end
  endtask

  task automatic do_reset(int a, int c);
    @(negedge clk);
    rst     = 1'b1;
    ratio_a = DIV_W'(a);
    ratio_c = DIV_W'(c);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", sync_n, 1'b1, -1);
    chk("R1", bank_a_clk, 1'b0, -1);
    chk("R1", bank_c_clk, 1'b0, -1);
    rst = 1'b0;
  endtask

  // One ratio pair over two coincidence periods plus a window.
  task automatic run_pair(int ra, int rc, string wtag);
    int a = eff(ra);
    int c = eff(rc);
    int l = a * c / gcd(a, c);
    int f = (a < c) ? a : c;
    int lows = 0;
    logic fast_prev = 1'b0;
    do_reset(ra, rc);
    for (int k = 0; k < 2 * l + f; k++) begin
      logic es;
      logic fast_now;
      @(posedge clk);
      @(negedge clk);
      es = exp_sync(k, a, c);
      chk("R2", bank_a_clk, exp_clk(k, a), k);
      chk("R2", bank_c_clk, exp_clk(k, c), k);
      if (es) chk("R5", sync_n, es, k);
      else    chk("R4", sync_n, es, k);
      if (k >= l && k < 2 * l && sync_n == 1'b0) lows++;
      fast_now = (a <= c) ? bank_a_clk : bank_c_clk;
      if (k == 2 * l - f) begin
        chk("R9", fast_now, 1'b1, k);
        chk("R9", fast_prev, 1'b0, k);
        chk("R9", sync_n, 1'b0, k);
      end
      fast_prev = fast_now;
    end
    n_chk++;
    if (lows != f) begin
      n_err++;
      $display("FAIL %s pair=%0d:%0d actual=%0d expected=%0d low cycles",
               wtag, ra, rc, lows, f);
    end
  endtask

  task automatic test_sweep();
    int as_[4] = '{2, 4, 6, 8};
    int cs_[4] = '{4, 6, 8, 12};
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        if (as_[i] == cs_[j]) run_pair(as_[i], cs_[j], "R7");
        else                  run_pair(as_[i], cs_[j], "R4");
      end
    end
  endtask

  task automatic test_non_integer();
    run_pair(3, 2, "R6");
    run_pair(2, 3, "R6");
  endtask

  task automatic test_clamp();
    run_pair(1, 6, "R3");
    run_pair(0, 1, "R3");
  endtask

  task automatic test_equal_low();
    do_reset(6, 6);
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R7", sync_n, 1'b0, k);
    end
  endtask

  // Ratio change mid-period: old ratios hold until the shared edge at k=12.
  task automatic test_change();
    do_reset(4, 6);
    for (int k = 0; k < 30; k++) begin
      int a;
      int c;
      int p;
      @(posedge clk);
      @(negedge clk);
      if (k < 12) begin a = 4; c = 6; p = k; end
      else        begin a = 2; c = 8; p = k - 12; end
      chk("R8", bank_a_clk, exp_clk(p, a), k);
      chk("R8", bank_c_clk, exp_clk(p, c), k);
      chk("R8", sync_n, exp_sync(p, a, c), k);
      if (k == 5) begin
        ratio_a = DIV_W'(2);
        ratio_c = DIV_W'(8);
      end
    end
  endtask

  initial begin
    test_sweep();
    test_non_integer();
    test_clamp();
    test_equal_low();
    test_change();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule